// File: doc/BRIEF.md
# Frame Statistics Counter Bank

This block keeps per-direction frame statistics for an Ethernet port. It watches two streams of frame-completion events, one for received frames and one for transmitted frames. Each event carries the frame length in bytes and an 8-bit status word. From these it updates a bank of saturating counters: total octets, total frames, frame types, error classes and seven length bins in the usual monitoring ranges.

Software reads the counters through a simple read port. Every read of a counter returns its value and restarts that counter from zero, so the caller accumulates totals in wider storage of its own. The octet counters are wider than one read word. Reading the low word captures the upper bits into a shadow, and a later read of the high word returns that shadow. A single clear input zeroes the whole bank.

Each event stream is valid/ready. A source holds `*_valid` together with its length and flags until it sees `*_ready` high at a rising edge. Ready is high in every cycle except the cycle in which `clr_all` is asserted, so the only back-pressure comes from a bank clear.

Top module: `rmon_stats`

## Requirements
- R1: `rx_ready` and `tx_ready` are high except in a cycle where `clr_all` is high. An event counts when valid and ready are both high at a rising edge. Its effect is visible to a read issued in the next cycle.
- R2: Every accepted event adds 1 to the frame counter (slot 2) and adds its length to the octet counter. The octet counter is `OCT_W` bits wide (45 by default). Frame and other counters are `CNT_W` bits wide (32 by default).
- R3: Flag bit 0 (multicast), bit 1 (broadcast) and bit 2 (pause) each add 1 to slot 3, slot 4 and slot 5 respectively. This applies in both directions.
- R4: Receive slot 6 counts frames with flag bit 3 (FCS error). Transmit slot 6 counts frames with bit 3 or bit 7 (underrun) set. Receive-only counters are:
  - slot 7, jabber, flag bit 4;
  - slot 8, short, any frame with length below 64;
  - slot 9, symbol error, flag bit 5;
  - slot 10, oversize, flag bit 6.
  Transmit slots 7 to 10 always read zero.
- R5: Length bins occupy slots 11 to 17, one per range: exactly 64, 65–127, 128–255, 256–511, 512–1023, 1024–1518, and 1519 or more. A frame shorter than 64 bytes lands in no bin.
- R6: A read is requested with `rd_en` and `rd_addr`. Bit 5 of `rd_addr` selects transmit (1) or receive (0), and bits 4:0 select the slot. `rd_data` and a `rd_valid` pulse follow one cycle later. Slots 18 to 31 read zero.
- R7: A read of any slot other than 1 returns the counter's value and clears it. An event accepted in the same cycle becomes the counter's new value.
- R8: A read of slot 0 returns the low `WORD_W` bits of the octet counter and latches the upper bits into a shadow. A read of slot 1 returns the shadow, zero-extended, and clears nothing.
- R9: Counters saturate at all ones instead of wrapping. This holds for both the `CNT_W` counters and the `OCT_W` octet counters.
- R10: `clr_all` zeroes every counter and both shadows at the next edge. No event is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_all | input | 1 | Zero all counters and shadows |
| rx_valid | input | 1 | Receive event valid |
| rx_ready | output | 1 | Receive event accepted |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_flags | input | 8 | Receive status flags |
| tx_valid | input | 1 | Transmit event valid |
| tx_ready | output | 1 | Transmit event accepted |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_flags | input | 8 | Transmit status flags |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Direction bit and slot |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | WORD_W | Read data |

## Verification
Both results of this block are due one rising edge after their cause. A read presented at an edge shows up on `rd_data` just after that edge. An event accepted at an edge is visible to a read issued at the following edge. The bench drives inputs on the falling edge and samples one nanosecond after the rising edge. It compares each read against a bench model that is updated in the order the hardware applies its effects at that edge: the read sees the old value, then the read clear, then the event or the bank clear. Same-cycle read and event collisions therefore resolve exactly as the requirements state.

// File: rtl/rmon_pkg.sv
package rmon_pkg;
  localparam int SLOT_W = 5;
  localparam int NSLOT  = 18;
  localparam int NCNT   = NSLOT - 2;
  localparam int FLAG_W = 8;

  // status flag bits
  localparam int F_MCAST = 0;
  localparam int F_BCAST = 1;
  localparam int F_PAUSE = 2;
  localparam int F_FCS   = 3;
  localparam int F_JAB   = 4;
  localparam int F_SYM   = 5;
  localparam int F_OVR   = 6;
  localparam int F_UNDR  = 7;

  // read slots
  localparam int S_OCT_LO = 0;
  localparam int S_OCT_HI = 1;
  localparam int S_FRM    = 2;
  localparam int S_MC     = 3;
  localparam int S_BC     = 4;
  localparam int S_PAUSE  = 5;
  localparam int S_ERR    = 6;
  localparam int S_JAB    = 7;
  localparam int S_SHORT  = 8;
  localparam int S_SYM    = 9;
  localparam int S_OVR    = 10;
  localparam int S_BIN0   = 11;
  localparam int NBIN     = 7;
endpackage

// File: rtl/rmon_classify.sv
module rmon_classify import rmon_pkg::*; #(
  parameter bit IS_RX = 1'b1,
  parameter int LEN_W = 14
) (
  input  logic              fire,
  input  logic [LEN_W-1:0]  len,
  input  logic [FLAG_W-1:0] flags,
  output logic [NCNT-1:0]   inc
);
  logic [31:0] l32;
  logic [NBIN-1:0] bin;
  assign l32 = 32'(len);

  always_comb begin
    bin = '0;
    if (l32 == 32'd64)        bin[0] = 1'b1;
    else if (l32 >= 32'd65 && l32 <= 32'd127)   bin[1] = 1'b1;
    else if (l32 >= 32'd128 && l32 <= 32'd255)  bin[2] = 1'b1;
    else if (l32 >= 32'd256 && l32 <= 32'd511)  bin[3] = 1'b1;
    else if (l32 >= 32'd512 && l32 <= 32'd1023) bin[4] = 1'b1;
    else if (l32 >= 32'd1024 && l32 <= 32'd1518) bin[5] = 1'b1;
    else if (l32 >= 32'd1519) bin[6] = 1'b1;
  end

  always_comb begin
    inc = '0;
    if (fire) begin
      inc[S_FRM-2]   = 1'b1;
      inc[S_MC-2]    = flags[F_MCAST];
      inc[S_BC-2]    = flags[F_BCAST];
      inc[S_PAUSE-2] = flags[F_PAUSE];
      inc[S_ERR-2]   = IS_RX ? flags[F_FCS] : (flags[F_FCS] | flags[F_UNDR]);
      if (IS_RX) begin
        inc[S_JAB-2]   = flags[F_JAB];
        inc[S_SHORT-2] = (l32 < 32'd64);
        inc[S_SYM-2]   = flags[F_SYM];
        inc[S_OVR-2]   = flags[F_OVR];
      end
      inc[S_BIN0-2 +: NBIN] = bin;
    end
  end
endmodule

// File: rtl/rmon_sat_ctr.sv
module rmon_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic         rd_clr,
  input  logic         add_en,
  input  logic [W-1:0] add_amt,
  output logic [W-1:0] count
);
  logic [W-1:0] base;
  logic [W:0]   sum;

  always_comb begin
    base = rd_clr ? '0 : count;
    sum  = {1'b0, base} + {1'b0, add_amt};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (clr_all) count <= '0;
    else if (add_en)  count <= sum[W] ? '1 : sum[W-1:0];
    else if (rd_clr)  count <= '0;
  end
endmodule

// File: rtl/rmon_dir.sv
module rmon_dir import rmon_pkg::*; #(
  parameter bit IS_RX  = 1'b1,
  parameter int LEN_W  = 14,
  parameter int CNT_W  = 32,
  parameter int OCT_W  = 45,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              fire,
  input  logic [LEN_W-1:0]  len,
  input  logic [FLAG_W-1:0] flags,
  input  logic              rd_hit,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [WORD_W-1:0] rd_val
);
  localparam int HI_W = OCT_W - WORD_W;

  logic [NCNT-1:0]  inc;
  logic [CNT_W-1:0] cnt [NCNT];
  logic [OCT_W-1:0] oct;
  logic [HI_W-1:0]  shadow;
  logic             lo_rd;

  assign lo_rd = rd_hit && (rd_slot == SLOT_W'(S_OCT_LO));

  rmon_classify #(.IS_RX(IS_RX), .LEN_W(LEN_W)) u_cls (
    .fire(fire), .len(len), .flags(flags), .inc(inc)
  );

  rmon_sat_ctr #(.W(OCT_W)) u_oct (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .rd_clr(lo_rd),
    .add_en(fire), .add_amt(OCT_W'(len)), .count(oct)
  );

  for (genvar j = 0; j < NCNT; j++) begin : g_cnt
    rmon_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
      .rd_clr(rd_hit && (rd_slot == SLOT_W'(j + 2))),
      .add_en(inc[j]), .add_amt(CNT_W'(1)), .count(cnt[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       shadow <= '0;
    else if (clr_all) shadow <= '0;
    else if (lo_rd)   shadow <= oct[OCT_W-1:WORD_W];
  end

  always_comb begin
    rd_val = '0;
    if (rd_slot == SLOT_W'(S_OCT_LO)) rd_val = oct[WORD_W-1:0];
    if (rd_slot == SLOT_W'(S_OCT_HI)) rd_val = WORD_W'(shadow);
    for (int j = 0; j < NCNT; j++)
      if (rd_slot == SLOT_W'(j + 2)) rd_val = WORD_W'(cnt[j]);
  end
endmodule

// File: rtl/rmon_stats.sv
module rmon_stats import rmon_pkg::*; #(
  parameter int LEN_W  = 14,
  parameter int CNT_W  = 32,
  parameter int OCT_W  = 45,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [FLAG_W-1:0] rx_flags,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [FLAG_W-1:0] tx_flags,
  input  logic              rd_en,
  input  logic [SLOT_W:0]   rd_addr,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic              rd_tx;
  logic [SLOT_W-1:0] rd_slot;
  logic [WORD_W-1:0] rx_val, tx_val;

  assign rx_ready = ~clr_all;
  assign tx_ready = ~clr_all;
  assign rd_tx    = rd_addr[SLOT_W];
  assign rd_slot  = rd_addr[SLOT_W-1:0];

  rmon_dir #(.IS_RX(1'b1), .LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W),
             .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .fire(rx_valid & rx_ready), .len(rx_len), .flags(rx_flags),
    .rd_hit(rd_en & ~rd_tx), .rd_slot(rd_slot), .rd_val(rx_val)
  );

  rmon_dir #(.IS_RX(1'b0), .LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W),
             .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .fire(tx_valid & tx_ready), .len(tx_len), .flags(tx_flags),
    .rd_hit(rd_en & rd_tx), .rd_slot(rd_slot), .rd_val(tx_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_tx ? tx_val : rx_val;
    end
  end
endmodule

// File: rtl/rmon_stats_chk.sv
module rmon_stats_chk import rmon_pkg::*; #(
  parameter int OCT_W  = 45,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_all,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rd_en,
  input logic [SLOT_W:0]   rd_addr,
  input logic [WORD_W-1:0] rd_data
);
  localparam int HI_W = OCT_W - WORD_W;

  logic [SLOT_W-1:0] slot;
  assign slot = rd_addr[SLOT_W-1:0];

  a_r10_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_all) && rd_en |=> rd_data == '0);

  a_r7_reread_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) && rd_addr == $past(rd_addr) && slot != SLOT_W'(S_OCT_HI)
    && !$past(rx_valid && rx_ready) && !$past(tx_valid && tx_ready) |=> rd_data == '0);

  a_r8_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && slot == SLOT_W'(S_OCT_HI) && $past(rd_en) && $past(rd_addr) == rd_addr
    && !$past(clr_all) |=> rd_data == $past(rd_data));

  a_r8_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && slot == SLOT_W'(S_OCT_HI) |=> (rd_data >> HI_W) == '0);

  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && slot >= SLOT_W'(NSLOT) |=> rd_data == '0);

  a_r4_tx_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr[SLOT_W] && slot >= SLOT_W'(S_JAB) && slot <= SLOT_W'(S_OVR)
    |=> rd_data == '0);
endmodule

bind rmon_stats rmon_stats_chk #(.OCT_W(OCT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_rmon_stats.sv
module test_rmon_stats;
  localparam int LEN_W  = 14;
  localparam int CNT_W  = 12;
  localparam int OCT_W  = 20;
  localparam int WORD_W = 16;
  localparam longint CNT_MAX = (64'd1 << CNT_W) - 1;
  localparam longint OCT_MAX = (64'd1 << OCT_W) - 1;
  localparam longint WMASK   = (64'd1 << WORD_W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, clr_all;
  logic              rx_valid, rx_ready, tx_valid, tx_ready;
  logic [LEN_W-1:0]  rx_len, tx_len;
  logic [7:0]        rx_flags, tx_flags;
  logic              rd_en, rd_valid;
  logic [5:0]        rd_addr;
  logic [WORD_W-1:0] rd_data;

  rmon_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W), .WORD_W(WORD_W)) i_rmon_stats (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_len(rx_len), .rx_flags(rx_flags),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_len(tx_len), .tx_flags(tx_flags),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  longint model [2][18];
  longint shadow [2];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int s);
    if (s == 0 || s == 2) return "R2";
    if (s == 1) return "R8";
    if (s <= 5) return "R3";
    if (s <= 10) return "R4";
    if (s <= 17) return "R5";
    return "R6";
  endfunction

  function automatic void bump(int d, int s);
    if (model[d][s] < CNT_MAX) model[d][s]++;
  endfunction

  function automatic void apply_ev(int d, int len, logic [7:0] f);
    model[d][0] = (model[d][0] + len > OCT_MAX) ? OCT_MAX : model[d][0] + len;
    bump(d, 2);
    if (f[0]) bump(d, 3);
    if (f[1]) bump(d, 4);
    if (f[2]) bump(d, 5);
    if (d == 0 ? f[3] : (f[3] | f[7])) bump(d, 6);
    if (d == 0) begin
      if (f[4]) bump(d, 7);
      if (len < 64) bump(d, 8);
      if (f[5]) bump(d, 9);
      if (f[6]) bump(d, 10);
    end
    if (len == 64) bump(d, 11);
    else if (len >= 65 && len <= 127) bump(d, 12);
    else if (len >= 128 && len <= 255) bump(d, 13);
    else if (len >= 256 && len <= 511) bump(d, 14);
    else if (len >= 512 && len <= 1023) bump(d, 15);
    else if (len >= 1024 && len <= 1518) bump(d, 16);
    else if (len >= 1519) bump(d, 17);
  endfunction

  task automatic step(bit rv, int rl, logic [7:0] rf, bit tv, int tl, logic [7:0] tf,
                      bit re, int ra, bit clr, string req = "");
    longint exp;
    int d, s;
    @(negedge clk);
    rx_valid = rv; rx_len = LEN_W'(rl); rx_flags = rf;
    tx_valid = tv; tx_len = LEN_W'(tl); tx_flags = tf;
    rd_en = re; rd_addr = 6'(ra); clr_all = clr;
    #1;
    if (clr) begin
      check("R1", longint'(rx_ready), 0, "rx_ready during clear");
      check("R1", longint'(tx_ready), 0, "tx_ready during clear");
    end
    @(posedge clk);
    #1;
    if (re) begin
      d = (ra >> 5) & 1;
      s = ra & 31;
      if (s == 0) exp = model[d][0] & WMASK;
      else if (s == 1) exp = shadow[d];
      else if (s < 18) exp = model[d][s];
      else exp = 0;
      check(req == "" ? req_of(s) : req, longint'(rd_data), exp,
            $sformatf("read dir %0d slot %0d", d, s));
      check("R6", longint'(rd_valid), 1, "rd_valid");
      if (s == 0) shadow[d] = model[d][0] >> WORD_W;
      if (s != 1 && s < 18) model[d][s] = 0;
    end
    if (clr) begin
      for (int i = 0; i < 2; i++) begin
        shadow[i] = 0;
        for (int j = 0; j < 18; j++) model[i][j] = 0;
      end
    end else begin
      if (rv) apply_ev(0, rl, rf);
      if (tv) apply_ev(1, tl, tf);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic read_all(string req = "");
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 20; s++) step(0, 0, 0, 0, 0, 0, 1, d * 32 + s, 0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens [14] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 9000};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin
      shadow[i] = 0;
      for (int j = 0; j < 18; j++) model[i][j] = 0;
    end
    rst_n = 0; clr_all = 0; rx_valid = 0; tx_valid = 0; rd_en = 0;
    rx_len = '0; tx_len = '0; rx_flags = '0; tx_flags = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R6", longint'(rd_valid), 0, "rd_valid after reset");
    check("R1", longint'(rx_ready), 1, "rx_ready idle");
    check("R1", longint'(tx_ready), 1, "tx_ready idle");
    read_all("R6");

    // R5: length bin boundaries in both directions
    foreach (lens[i]) step(1, lens[i], 8'h00, 1, lens[i], 8'h00, 0, 0, 0);
    read_all("R5");

    // R3/R4: each flag, tx receive-only flags must not count
    for (int b = 0; b < 8; b++) step(1, 100, 8'(1 << b), 1, 100, 8'(1 << b), 0, 0, 0);
    step(1, 40, 8'h70, 1, 40, 8'h70, 0, 0, 0);
    read_all("R4");

    // R7: event in same cycle as read of that counter
    step(1, 70, 8'h01, 0, 0, 0, 0, 0, 0);
    step(1, 70, 8'h01, 0, 0, 0, 1, 2, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 2, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 2, 0, "R7");

    // R8: shadow of the octet high bits
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 16000, 8'h00, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 33, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 32, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 33, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 33, 0, "R8");
    read_all();

    // R9: saturation of frame, multicast, bin and octet counters
    for (int i = 0; i < 4200; i++) step(1, 300, 8'h01, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 2, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 3, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 14, 0, "R9");

    // R10: clear with an event offered in the same cycle
    for (int i = 0; i < 4; i++) step(1, 500, 8'h07, 1, 600, 8'h88, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 500, 8'h07, 1, 600, 8'h88, 0, 0, 1);
    read_all("R10");

    // random traffic mixed with reads and rare clears
    for (int i = 0; i < 3000; i++) begin
      int rl, tl;
      rl = ($urandom % 4 == 0) ? lens[$urandom % 14] : int'($urandom_range(20, 2000));
      tl = ($urandom % 4 == 0) ? lens[$urandom % 14] : int'($urandom_range(20, 2000));
      step($urandom % 2, rl, 8'($urandom), $urandom % 2, tl, 8'($urandom),
           ($urandom % 3) == 0, int'(($urandom % 2) * 32 + ($urandom % 24)),
           ($urandom % 100) == 0);
    end
    idle();
    read_all();
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule